// File: doc/BRIEF.md
# Shared Register Bus Datapath

This block is the data side of a small accumulator machine. Six working registers and a 4096-word memory all talk through one 16-bit bus. In every cycle a 3-bit source code picks the one source that drives the bus. Any register whose load strobe is raised captures that bus value at the next rising clock edge. The memory can also write the bus value into the word addressed by the address register. Two registers are 12 bits wide: the address register and the program counter. They show up on the bus with their top four bits forced to zero. The other four registers are 16 bits wide: data, accumulator, instruction and temporary.

The accumulator is not loaded from the bus. It is loaded from a small arithmetic unit, which offers four choices:

- copy the data register;
- add the data register to the accumulator, putting the carry into a one-bit extension flag;
- take the 8-bit input register;
- keep the accumulator as it is.

An external device writes bytes into the input register. The output register captures the low byte of the bus for a device to read. A control sequencer outside this block drives all the strobes one cycle at a time.

Top module: `cbus_datapath`

## Requirements
- R1: While reset is held and right after it is released, every register reads zero on the bus for all source codes 000 to 110. The extension flag and the output byte are also zero.
- R2: Source code 000 puts zero on the bus. Codes 001 to 110 put a register on the bus: 001 the address register, 010 the program counter, 011 the data register, 100 the accumulator, 101 the instruction register, 110 the temporary register. The two 12-bit registers appear with bus bits 15..12 at zero.
- R3: A register whose load bit is set captures the bus at the rising edge. The 12-bit registers take bus bits 11..0. Load bit positions are 0 for the address register, 1 for the program counter, 2 for the data register, 3 for the accumulator, 4 for the instruction register and 5 for the temporary register. Clear and increment use the same bit positions.
- R4: The increment bit adds one at the edge and wraps at the register's own width, so 12-bit 0xFFF becomes 0x000. Incrementing the accumulator leaves the extension flag unchanged.
- R5: When more than one control is set for the same register, clear takes priority over load, and load takes priority over increment.
- R6: Source code 111 puts the memory word at the address register's value on the bus. When the write strobe is set, that word takes the bus value at the edge, using the address held before that edge.
- R7: When the accumulator load bit is set, the accumulator takes the result of the arithmetic unit. The operation codes are:
  - 00: the data register;
  - 01: the accumulator plus the data register, with the carry-out written to the extension flag;
  - 10: the input byte, zero-extended to 16 bits;
  - 11: the accumulator unchanged.

  Only code 01 changes the extension flag.
- R8: The extension-flag clear strobe zeroes the flag at the edge, and it wins over a carry from an add in the same cycle.
- R9: The input strobe loads the input byte into the input register and has no direct effect on the bus. The output strobe loads bus bits 7..0 into the output byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Bus source code |
| reg_ld | input | 6 | Per-register load strobes |
| reg_inc | input | 6 | Per-register increment strobes |
| reg_clr | input | 6 | Per-register clear strobes |
| mem_wr | input | 1 | Write the bus into memory at the address register |
| alu_op | input | 2 | Arithmetic unit operation for the accumulator |
| e_clr | input | 1 | Clear the extension flag |
| in_data | input | 8 | Byte from the external device |
| in_ld | input | 1 | Capture in_data into the input register |
| out_ld | input | 1 | Capture bus bits 7..0 into the output byte |
| bus_data | output | 16 | Current bus value |
| out_data | output | 8 | Output byte to the device |
| e_flag | output | 1 | Extension flag |

## Verification
The bus value depends on the source code and on the register or memory contents combinationally, so it is due in the same cycle as the source code. Any load, increment, clear, memory write, flag change or output capture goes through exactly one register, so its effect is due in the cycle after the controlling strobe. The driver applies each cycle's controls just after the falling edge. It predicts that cycle's bus value, flag and output byte from the state its own model holds before the coming edge, and then advances the model. The monitor compares these predictions one time unit before the rising edge, after the combinational paths have settled and before any register moves.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 12;
  localparam int IO_W     = 8;
  localparam int NUM_REGS = 6;

  localparam int RI_AR = 0;
  localparam int RI_PC = 1;
  localparam int RI_DR = 2;
  localparam int RI_AC = 3;
  localparam int RI_IR = 4;
  localparam int RI_TR = 5;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } src_e;

  typedef enum logic [1:0] {
    ALU_PASS_DR = 2'd0,
    ALU_ADD     = 2'd1,
    ALU_TAKE_IN = 2'd2,
    ALU_HOLD    = 2'd3
  } alu_op_e;

  function automatic int reg_width(int idx, int aw, int dw);
    return (idx == RI_AR || idx == RI_PC) ? aw : dw;
  endfunction

  function automatic logic [DATA_W:0] add_carry(logic [DATA_W-1:0] a,
                                                logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction
endpackage

// File: rtl/cbus_reg.sv
module cbus_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic         inc,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic do_clr, do_ld, do_inc, do_hold;
  assign do_clr  = clr;
  assign do_ld   = ld && !clr;
  assign do_inc  = inc && !ld && !clr;
  assign do_hold = !inc && !ld && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (do_clr) q <= '0;
    else if (do_ld)  q <= d;
    else if (do_inc) q <= q + W'(1);
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> q == '0); // R5
  AST_LD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    do_ld |=> q == $past(d)); // R3
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    do_inc |=> q == $past(q) + W'(1)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    do_hold |=> $stable(q)); // R3
endmodule

// File: rtl/cbus_mem.sv
module cbus_mem #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];

  AST_MEM_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (addr != $past(addr)) || (rdata == $past(wdata))); // R6
endmodule

// File: rtl/cbus_srcmux.sv
module cbus_srcmux
  import cbus_pkg::*;
#(
  parameter int DW = 16,
  parameter int NR = 6
) (
  input  src_e                  sel,
  input  logic [NR-1:0][DW-1:0] srcs,
  input  logic [DW-1:0]         mem_word,
  output logic [DW-1:0]         bus
);
  always_comb begin
    bus = '0;
    if (sel == SRC_MEM) begin
      bus = mem_word;
    end else begin
      for (int i = 0; i < NR; i++) begin
        if (int'(sel) == i + 1) bus = srcs[i];
      end
    end
  end
endmodule

// File: rtl/cbus_alu.sv
module cbus_alu
  import cbus_pkg::*;
#(
  parameter int DW  = 16,
  parameter int IOW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  alu_op_e        op,
  input  logic           ac_ld,
  input  logic           e_clr,
  input  logic [DW-1:0]  ac,
  input  logic [DW-1:0]  dr,
  input  logic [IOW-1:0] inpr,
  output logic [DW-1:0]  res,
  output logic           e
);
  logic [DW:0] sum;
  logic        carry_out;
  logic        e_take;

  assign sum       = add_carry(ac, dr);
  assign carry_out = sum[DW];
  assign e_take    = ac_ld && (op == ALU_ADD) && !e_clr;

  always_comb begin
    unique case (op)
      ALU_PASS_DR: res = dr;
      ALU_ADD:     res = sum[DW-1:0];
      ALU_TAKE_IN: res = DW'(inpr);
      default:     res = ac;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      e <= 1'b0;
    else if (e_clr)  e <= 1'b0;
    else if (e_take) e <= carry_out;
  end

  AST_E_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    e_clr |=> !e); // R8
  AST_E_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!e_clr && !(ac_ld && op == ALU_ADD)) |=> $stable(e)); // R7
  AST_E_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    e_take |=> e == ($past({1'b0, ac} + {1'b0, dr}) >> DW)); // R7
endmodule

// File: rtl/cbus_io.sv
module cbus_io #(
  parameter int IOW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_ld,
  input  logic [IOW-1:0] in_data,
  input  logic           out_ld,
  input  logic [IOW-1:0] out_src,
  output logic [IOW-1:0] inpr,
  output logic [IOW-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inpr     <= '0;
      out_data <= '0;
    end else begin
      if (in_ld)  inpr     <= in_data;
      if (out_ld) out_data <= out_src;
    end
  end

  AST_OUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    out_ld |=> out_data == $past(out_src)); // R9
  AST_OUT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ld |=> $stable(out_data)); // R9
endmodule

// File: rtl/cbus_datapath.sv
module cbus_datapath
  import cbus_pkg::*;
#(
  parameter int DATA_W_P = DATA_W,
  parameter int ADDR_W_P = ADDR_W,
  parameter int IO_W_P   = IO_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          bus_sel,
  input  logic [NUM_REGS-1:0] reg_ld,
  input  logic [NUM_REGS-1:0] reg_inc,
  input  logic [NUM_REGS-1:0] reg_clr,
  input  logic                mem_wr,
  input  logic [1:0]          alu_op,
  input  logic                e_clr,
  input  logic [IO_W_P-1:0]   in_data,
  input  logic                in_ld,
  input  logic                out_ld,
  output logic [DATA_W_P-1:0] bus_data,
  output logic [IO_W_P-1:0]   out_data,
  output logic                e_flag
);
  logic [NUM_REGS-1:0][DATA_W_P-1:0] reg_q;
  logic [DATA_W_P-1:0] bus;
  logic [DATA_W_P-1:0] mem_word;
  logic [DATA_W_P-1:0] alu_res;
  logic [IO_W_P-1:0]   inpr;
  src_e                sel;
  alu_op_e             op;

  assign sel = src_e'(bus_sel);
  assign op  = alu_op_e'(alu_op);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam int W = reg_width(g, ADDR_W_P, DATA_W_P);
    logic [W-1:0] d;
    logic [W-1:0] q;
    if (g == RI_AC) begin : g_from_alu
      assign d = alu_res[W-1:0];
    end else begin : g_from_bus
      assign d = bus[W-1:0];
    end
    cbus_reg #(.W(W)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (reg_clr[g]),
      .ld   (reg_ld[g]),
      .inc  (reg_inc[g]),
      .d    (d),
      .q    (q)
    );
    assign reg_q[g] = DATA_W_P'(q);
  end

  cbus_srcmux #(.DW(DATA_W_P), .NR(NUM_REGS)) u_mux (
    .sel     (sel),
    .srcs    (reg_q),
    .mem_word(mem_word),
    .bus     (bus)
  );

  cbus_mem #(.DW(DATA_W_P), .AW(ADDR_W_P)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_wr),
    .addr (reg_q[RI_AR][ADDR_W_P-1:0]),
    .wdata(bus),
    .rdata(mem_word)
  );

  cbus_alu #(.DW(DATA_W_P), .IOW(IO_W_P)) u_alu (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (op),
    .ac_ld(reg_ld[RI_AC]),
    .e_clr(e_clr),
    .ac   (reg_q[RI_AC]),
    .dr   (reg_q[RI_DR]),
    .inpr (inpr),
    .res  (alu_res),
    .e    (e_flag)
  );

  cbus_io #(.IOW(IO_W_P)) u_io (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_ld   (in_ld),
    .in_data (in_data),
    .out_ld  (out_ld),
    .out_src (bus[IO_W_P-1:0]),
    .inpr    (inpr),
    .out_data(out_data)
  );

  assign bus_data = bus;

  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_AR || sel == SRC_PC) |-> bus[DATA_W_P-1:ADDR_W_P] == '0); // R2
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_NONE) |-> bus == '0); // R2
  AST_AC_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_ld[RI_AC] && !reg_clr[RI_AC] && op == ALU_ADD) |=>
      reg_q[RI_AC] == DATA_W_P'($past(reg_q[RI_AC]) + $past(reg_q[RI_DR]))); // R7
endmodule

// File: tb/cbus_datapath_test.sv
module cbus_datapath_test;
  localparam int CLK_PERIOD = 10;
  localparam int AR = 0, PC = 1, DR = 2, AC = 3, IR = 4, TR = 5;

  typedef struct {
    logic [2:0]  sel;
    logic [5:0]  ld, inc, clr;
    logic        mw;
    logic [1:0]  op;
    logic        ec, ild, old;
    logic [7:0]  idat;
  } ctl_t;

  typedef struct {
    logic [15:0] bus;
    logic        bus_chk;
    logic [7:0]  outd;
    logic        e;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_sel = '0;
  logic [5:0] reg_ld = '0, reg_inc = '0, reg_clr = '0;
  logic mem_wr = 1'b0, e_clr = 1'b0, in_ld = 1'b0, out_ld = 1'b0;
  logic [1:0] alu_op = '0;
  logic [7:0] in_data = '0;
  logic [15:0] bus_data;
  logic [7:0] out_data;
  logic e_flag;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  item_t sbq[$];

  logic [11:0] m_ar, m_pc;
  logic [15:0] m_dr, m_ac, m_ir, m_tr;
  logic [7:0]  m_inpr, m_outr;
  logic        m_e;
  logic [15:0] mem_m [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  cbus_datapath uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .reg_ld(reg_ld),
    .reg_inc(reg_inc), .reg_clr(reg_clr), .mem_wr(mem_wr), .alu_op(alu_op),
    .e_clr(e_clr), .in_data(in_data), .in_ld(in_ld), .out_ld(out_ld),
    .bus_data(bus_data), .out_data(out_data), .e_flag(e_flag)
  );

  function automatic ctl_t nop();
    ctl_t c;
    c.sel = 3'd0; c.ld = '0; c.inc = '0; c.clr = '0; c.mw = 1'b0;
    c.op = 2'd0; c.ec = 1'b0; c.ild = 1'b0; c.old = 1'b0; c.idat = '0;
    return c;
  endfunction

  function automatic logic [15:0] step_reg(logic [15:0] cur, logic [15:0] mask,
                                           logic c, logic l, logic i, logic [15:0] d);
    if (c) return 16'h0;
    if (l) return d & mask;
    if (i) return (cur + 16'h1) & mask;
    return cur;
  endfunction

  task automatic step(input ctl_t c, input string tag);
    item_t it;
    logic [15:0] b, aluv, nxt;
    logic [16:0] s17;
    @(negedge clk);
    bus_sel = c.sel; reg_ld = c.ld; reg_inc = c.inc; reg_clr = c.clr;
    mem_wr = c.mw; alu_op = c.op; e_clr = c.ec; in_ld = c.ild;
    in_data = c.idat; out_ld = c.old;
    it.bus_chk = 1'b1;
    case (c.sel)
      3'd0: b = 16'h0;
      3'd1: b = {4'h0, m_ar};
      3'd2: b = {4'h0, m_pc};
      3'd3: b = m_dr;
      3'd4: b = m_ac;
      3'd5: b = m_ir;
      3'd6: b = m_tr;
      default: begin
        if (mem_m.exists(int'(m_ar))) b = mem_m[int'(m_ar)];
        else begin b = 16'h0; it.bus_chk = 1'b0; end
      end
    endcase
    it.bus = b; it.outd = m_outr; it.e = m_e; it.tag = tag;
    sbq.push_back(it);
    s17 = {1'b0, m_ac} + {1'b0, m_dr};
    case (c.op)
      2'd0: aluv = m_dr;
      2'd1: aluv = s17[15:0];
      2'd2: aluv = {8'h00, m_inpr};
      default: aluv = m_ac;
    endcase
    if (c.mw) mem_m[int'(m_ar)] = b;
    if (c.ec) m_e = 1'b0;
    else if (c.ld[AC] && c.op == 2'd1) m_e = s17[16];
    if (c.old) m_outr = b[7:0];
    if (c.ild) m_inpr = c.idat;
    nxt = step_reg({4'h0, m_ar}, 16'h0FFF, c.clr[AR], c.ld[AR], c.inc[AR], b);
    m_ar = nxt[11:0];
    nxt = step_reg({4'h0, m_pc}, 16'h0FFF, c.clr[PC], c.ld[PC], c.inc[PC], b);
    m_pc = nxt[11:0];
    m_dr = step_reg(m_dr, 16'hFFFF, c.clr[DR], c.ld[DR], c.inc[DR], b);
    m_ac = step_reg(m_ac, 16'hFFFF, c.clr[AC], c.ld[AC], c.inc[AC], aluv);
    m_ir = step_reg(m_ir, 16'hFFFF, c.clr[IR], c.ld[IR], c.inc[IR], b);
    m_tr = step_reg(m_tr, 16'hFFFF, c.clr[TR], c.ld[TR], c.inc[TR], b);
  endtask

  task automatic look(input logic [2:0] s, input string tag);
    ctl_t c = nop(); c.sel = s; step(c, tag);
  endtask

  task automatic xfer(input logic [2:0] s, input int dst, input string tag);
    ctl_t c = nop(); c.sel = s; c.ld[dst] = 1'b1; step(c, tag);
  endtask

  task automatic alu(input logic [1:0] op, input string tag);
    ctl_t c = nop(); c.ld[AC] = 1'b1; c.op = op; step(c, tag);
  endtask

  task automatic inp(input logic [7:0] v, input string tag);
    ctl_t c = nop(); c.ild = 1'b1; c.idat = v; step(c, tag);
  endtask

  task automatic double_ac(input string tag);
    xfer(3'd4, DR, tag);
    alu(2'd1, tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/2 - 1);
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        vectors++;
        if (it.bus_chk && bus_data !== it.bus) begin
          miscompares++;
          $display("FAIL %s bus actual %h expected %h", it.tag, bus_data, it.bus);
        end
        if (out_data !== it.outd) begin
          miscompares++;
          $display("FAIL %s out_data actual %h expected %h", it.tag, out_data, it.outd);
        end
        if (e_flag !== it.e) begin
          miscompares++;
          $display("FAIL %s e_flag actual %b expected %b", it.tag, e_flag, it.e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual running expected finished");
    summary();
  end

  initial begin : driver
    ctl_t c;
    m_ar = '0; m_pc = '0; m_dr = '0; m_ac = '0; m_ir = '0; m_tr = '0;
    m_inpr = '0; m_outr = '0; m_e = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: every register source reads zero after reset
    for (int s = 0; s < 7; s++) look(3'(s), "R1");
    // R9: input strobe alone leaves the bus unchanged
    inp(8'hFF, "R9");
    look(3'd4, "R9");
    // R7: take input byte into accumulator
    alu(2'd2, "R7");
    look(3'd4, "R7");
    // R3: bus loads, 12-bit truncation
    xfer(3'd4, DR, "R3");
    look(3'd3, "R3");
    xfer(3'd3, AR, "R3");
    look(3'd1, "R2");
    // R7: repeated doubling, last one carries into E
    for (int k = 0; k < 9; k++) double_ac("R7");
    look(3'd4, "R7");
    look(3'd0, "R2");
    xfer(3'd4, AR, "R3");
    look(3'd1, "R2");
    xfer(3'd4, PC, "R3");
    c = nop(); c.inc[PC] = 1'b1; step(c, "R4");
    look(3'd2, "R4");
    // R8: clear beats a carrying add
    c = nop(); c.ld[AC] = 1'b1; c.op = 2'd1; c.ec = 1'b1; step(c, "R8");
    look(3'd4, "R8");
    // build 0x0FFF for wrap tests
    c = nop(); c.clr[AC] = 1'b1; step(c, "R5");
    inp(8'hFF, "R9");
    alu(2'd2, "R7");
    for (int k = 0; k < 4; k++) double_ac("R7");
    xfer(3'd4, DR, "R3");
    inp(8'h0F, "R9");
    alu(2'd2, "R7");
    alu(2'd1, "R7");
    look(3'd4, "R7");
    xfer(3'd4, AR, "R3");
    look(3'd1, "R3");
    c = nop(); c.inc[AR] = 1'b1; step(c, "R4");
    look(3'd1, "R4");
    xfer(3'd4, PC, "R3");
    c = nop(); c.inc[PC] = 1'b1; step(c, "R4");
    look(3'd2, "R4");
    // R4: accumulator increment leaves E alone; hold op keeps value
    c = nop(); c.inc[AC] = 1'b1; step(c, "R4");
    look(3'd4, "R4");
    alu(2'd3, "R7");
    look(3'd4, "R7");
    // R5: priority on the temporary register
    c = nop(); c.sel = 3'd4; c.ld[TR] = 1'b1; c.inc[TR] = 1'b1; c.clr[TR] = 1'b1;
    step(c, "R5");
    look(3'd6, "R5");
    c = nop(); c.sel = 3'd4; c.ld[TR] = 1'b1; c.inc[TR] = 1'b1; step(c, "R5");
    look(3'd6, "R5");
    c = nop(); c.inc[TR] = 1'b1; c.clr[TR] = 1'b1; step(c, "R5");
    look(3'd6, "R5");
    c = nop(); c.inc[TR] = 1'b1; step(c, "R4");
    look(3'd6, "R4");
    // R6: memory write and readback
    c = nop(); c.sel = 3'd4; c.mw = 1'b1; step(c, "R6");
    look(3'd7, "R6");
    c = nop(); c.inc[AR] = 1'b1; step(c, "R6");
    c = nop(); c.sel = 3'd3; c.mw = 1'b1; step(c, "R6");
    look(3'd7, "R6");
    c = nop(); c.clr[AR] = 1'b1; step(c, "R6");
    look(3'd7, "R6");
    c = nop(); c.sel = 3'd6; c.mw = 1'b1; c.ld[AR] = 1'b1; step(c, "R6");
    look(3'd1, "R6");
    c = nop(); c.clr[AR] = 1'b1; step(c, "R6");
    look(3'd7, "R6");
    xfer(3'd7, IR, "R6");
    look(3'd5, "R3");
    c = nop(); c.inc[AR] = 1'b1; step(c, "R6");
    xfer(3'd7, DR, "R6");
    look(3'd3, "R6");
    alu(2'd0, "R7");
    look(3'd4, "R7");
    // R9: output byte capture
    inp(8'h5A, "R9");
    alu(2'd2, "R7");
    c = nop(); c.sel = 3'd4; c.old = 1'b1; step(c, "R9");
    look(3'd4, "R9");
    c = nop(); c.sel = 3'd3; step(c, "R9");
    look(3'd0, "R9");
    repeat (3) @(negedge clk);
    summary();
  end
endmodule